// File: doc/BRIEF.md
# Secured One-Time-Programmable Program Store

This block holds a one-time-programmable program array together with a small configuration store: one configuration byte and a bank of user-data bytes. An external programmer reaches all three through one port. It drives an address, write data, a two-bit target select and read, write and erase strobes. Read data comes back one cycle later with a valid flag. The processor core has a separate read-only fetch port into the program array. The configuration byte and the user bytes cannot be reached from that port.

Programming follows floating-gate rules. Erase drives every bit to 1, and a write can only clear bits, so each write stores the old value ANDed with the new one. One bit of the configuration byte is the protection bit. Once it is programmed, the external port hides the array and the user bytes and refuses every write. Erase still works, but the protection bit survives it. A protected part can therefore be blanked but never programmed again. Every refused write produces a one-cycle reject pulse. The core fetch port is not affected by protection.

The rst_n input models first power-up of a fresh, blank and unprotected die.

Top module: `otp_secure_ctrl`

## Requirements
- R1: After reset every array location, every user byte and the configuration byte read 0xFF, and ext_rvalid and ext_reject are low.
- R2: An external read (ext_rd high for one cycle) returns its data on ext_rdata one cycle later, and ext_rvalid is high in that cycle only. ext_sel selects the target: 0 = program array at ext_addr, 1 = configuration byte, 2 = user byte at ext_addr[2:0], 3 = no target (reads 0xFF, writes ignored).
- R3: While unprotected, an external write stores old AND ext_wdata in the selected target.
- R4: Erase sets all array and user bytes to 0xFF. It sets the configuration byte to 0xFF, except that the protection bit keeps its value.
- R5: Configuration bit 3 is the protection bit, and 0 means protected. Writing the configuration byte with bit 3 cleared protects the part.
- R6: While protected, external reads of the array or of user bytes return 0xFF whatever is stored.
- R7: While protected, the configuration byte still reads back its true stored value (0xF7 after protecting from the erased state).
- R8: While protected, external writes to any target change nothing. ext_reject is high for exactly the one cycle after each such write. Otherwise ext_reject stays low.
- R9: Once set, protection persists through erase. After that erase, writes are still refused.
- R10: fetch_data shows the true array contents at fetch_addr one cycle after fetch_en, whatever the protection state. It holds its value when fetch_en is low.
- R11: Reads from either port observe contents from before any write or erase in the same cycle. When erase and write are strobed together, erase wins and the write is dropped without a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up initialisation to a blank part |
| ext_addr | input | AW | External address (array index or user-byte index) |
| ext_wdata | input | DW | External write data |
| ext_sel | input | 2 | Target select: array, configuration, user data, none |
| ext_rd | input | 1 | External read strobe |
| ext_wr | input | 1 | External write strobe |
| ext_erase | input | 1 | Erase strobe |
| ext_rdata | output | DW | External read data |
| ext_rvalid | output | 1 | External read data valid |
| ext_reject | output | 1 | Pulse for a write refused by protection |
| fetch_en | input | 1 | Core fetch strobe |
| fetch_addr | input | AW | Core fetch address |
| fetch_data | output | DW | Core fetch data |

## Verification
The collisions that matter are a program write landing in the same cycle as a core fetch and an external read of the same address, and an erase landing together with a write. The bench strobes the write, the external read and the fetch in one cycle and expects the fetch and the read to return the erased value. A later read must then show the programmed byte. For erase and write together, it expects a blank array, no reject pulse and no trace of the write data.

// File: rtl/otp_pkg.sv
package otp_pkg;
   typedef enum logic [1:0] {
      SEL_ARRAY = 2'b00,
      SEL_CFG   = 2'b01,
      SEL_USER  = 2'b10,
      SEL_NONE  = 2'b11
   } otp_sel_e;
endpackage

// File: rtl/otp_access_gate.sv
module otp_access_gate
   import otp_pkg::*;
(
   input  logic       ext_rd,
   input  logic       ext_wr,
   input  logic       ext_erase,
   input  logic [1:0] ext_sel,
   input  logic       secured,
   output logic       arr_we,
   output logic       cfg_we,
   output logic       usr_we,
   output logic       arr_rd,
   output logic       cs_rd,
   output logic       rd_mask,
   output logic       reject_set
);
   otp_sel_e sel;
   logic     wr_ok;

   always_comb begin
      sel        = otp_sel_e'(ext_sel);
      wr_ok      = ext_wr && !ext_erase && !secured;
      arr_we     = wr_ok && (sel == SEL_ARRAY);
      cfg_we     = wr_ok && (sel == SEL_CFG);
      usr_we     = wr_ok && (sel == SEL_USER);
      arr_rd     = ext_rd && (sel == SEL_ARRAY);
      cs_rd      = ext_rd && ((sel == SEL_CFG) || (sel == SEL_USER));
      rd_mask    = (sel == SEL_NONE) || (secured && (sel != SEL_CFG));
      reject_set = ext_wr && !ext_erase && secured;
   end
endmodule

// File: rtl/otp_prog_array.sv
module otp_prog_array #(
   parameter int DEPTH = 256,
   parameter int DW    = 8,
   parameter int AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          erase,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          rd_en,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata_q,
   input  logic          fetch_en,
   input  logic [AW-1:0] fetch_addr,
   output logic [DW-1:0] fetch_q
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (erase) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (we) begin
         mem[waddr] <= mem[waddr] & wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '1;
         fetch_q <= '1;
      end else begin
         if (rd_en)    rdata_q <= mem[raddr];
         if (fetch_en) fetch_q <= mem[fetch_addr];
      end
   end
endmodule

// File: rtl/otp_cfg_store.sv
module otp_cfg_store #(
   parameter int DW      = 8,
   parameter int USR_N   = 8,
   parameter int UAW     = 3,
   parameter int SEC_BIT = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cfg_we,
   input  logic           usr_we,
   input  logic           erase,
   input  logic [DW-1:0]  wdata,
   input  logic [UAW-1:0] usr_idx,
   input  logic           rd_en,
   input  logic           rd_cfg,
   output logic [DW-1:0]  rdata_q,
   output logic           secured
);
   localparam logic [DW-1:0] SEC_MASK = DW'(1) << SEC_BIT;

   logic [DW-1:0] cfg_q;
   logic [DW-1:0] cfg_blank;
   logic [DW-1:0] usr_q [USR_N];
   logic [DW-1:0] usr_val;

   assign cfg_blank = ~SEC_MASK | (cfg_q & SEC_MASK);
   assign secured   = ~cfg_q[SEC_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '1;
      else if (erase)  cfg_q <= cfg_blank;
      else if (cfg_we) cfg_q <= cfg_q & wdata;
   end

   for (genvar g = 0; g < USR_N; g++) begin : g_usr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            usr_q[g] <= '1;
         else if (erase)
            usr_q[g] <= '1;
         else if (usr_we && (usr_idx == UAW'(g)))
            usr_q[g] <= usr_q[g] & wdata;
      end
   end

   always_comb begin
      usr_val = '1;
      for (int i = 0; i < USR_N; i++)
         if (usr_idx == UAW'(i)) usr_val = usr_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '1;
      else if (rd_en) rdata_q <= rd_cfg ? cfg_q : usr_val;
   end
endmodule

// File: rtl/otp_secure_ctrl.sv
module otp_secure_ctrl
   import otp_pkg::*;
#(
   parameter int DEPTH   = 256,
   parameter int DW      = 8,
   parameter int USR_N   = 8,
   parameter int SEC_BIT = 3,
   localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int UAW    = (USR_N > 1) ? $clog2(USR_N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] ext_addr,
   input  logic [DW-1:0] ext_wdata,
   input  logic [1:0]    ext_sel,
   input  logic          ext_rd,
   input  logic          ext_wr,
   input  logic          ext_erase,
   output logic [DW-1:0] ext_rdata,
   output logic          ext_rvalid,
   output logic          ext_reject,
   input  logic          fetch_en,
   input  logic [AW-1:0] fetch_addr,
   output logic [DW-1:0] fetch_data
);
   initial begin
      assert (DEPTH >= 2) else $fatal(1, "DEPTH must be at least 2");
      assert (USR_N >= 1 && USR_N <= 8) else $fatal(1, "USR_N must be 1..8");
      assert (SEC_BIT >= 0 && SEC_BIT < DW) else $fatal(1, "SEC_BIT outside byte");
      assert (AW >= UAW) else $fatal(1, "address narrower than user index");
   end

   logic          secured;
   logic          arr_we, cfg_we, usr_we, arr_rd, cs_rd, rd_mask, reject_set;
   logic [DW-1:0] arr_rdata, cs_rdata;
   logic          src_arr_q, mask_q, rvalid_q, reject_q;

   otp_access_gate u_gate (
      .ext_rd    (ext_rd),
      .ext_wr    (ext_wr),
      .ext_erase (ext_erase),
      .ext_sel   (ext_sel),
      .secured   (secured),
      .arr_we    (arr_we),
      .cfg_we    (cfg_we),
      .usr_we    (usr_we),
      .arr_rd    (arr_rd),
      .cs_rd     (cs_rd),
      .rd_mask   (rd_mask),
      .reject_set(reject_set)
   );

   otp_prog_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (arr_we),
      .erase     (ext_erase),
      .waddr     (ext_addr),
      .wdata     (ext_wdata),
      .rd_en     (arr_rd),
      .raddr     (ext_addr),
      .rdata_q   (arr_rdata),
      .fetch_en  (fetch_en),
      .fetch_addr(fetch_addr),
      .fetch_q   (fetch_data)
   );

   otp_cfg_store #(.DW(DW), .USR_N(USR_N), .UAW(UAW), .SEC_BIT(SEC_BIT)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_we  (cfg_we),
      .usr_we  (usr_we),
      .erase   (ext_erase),
      .wdata   (ext_wdata),
      .usr_idx (ext_addr[UAW-1:0]),
      .rd_en   (cs_rd),
      .rd_cfg  (ext_sel == SEL_CFG),
      .rdata_q (cs_rdata),
      .secured (secured)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_arr_q <= 1'b0;
         mask_q    <= 1'b1;
         rvalid_q  <= 1'b0;
         reject_q  <= 1'b0;
      end else begin
         rvalid_q <= ext_rd;
         reject_q <= reject_set;
         if (ext_rd) begin
            src_arr_q <= arr_rd;
            mask_q    <= rd_mask;
         end
      end
   end

   assign ext_rdata  = mask_q ? '1 : (src_arr_q ? arr_rdata : cs_rdata);
   assign ext_rvalid = rvalid_q;
   assign ext_reject = reject_q;
endmodule

// File: rtl/otp_secure_chk.sv
module otp_secure_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ext_rd,
   input logic          ext_wr,
   input logic          ext_erase,
   input logic [1:0]    ext_sel,
   input logic [DW-1:0] ext_rdata,
   input logic          ext_rvalid,
   input logic          ext_reject,
   input logic          fetch_en,
   input logic [DW-1:0] fetch_data,
   input logic          secured
);
   AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n) ext_rvalid |-> $past(ext_rd)); // R2
   AST_READ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n) ext_rd |=> ext_rvalid); // R2
   AST_SECURE_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ext_rvalid && $past(secured) && ($past(ext_sel) != 2'b01)) |-> (ext_rdata == {DW{1'b1}})); // R6
   AST_REJECT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) ext_reject |-> $past(ext_wr && !ext_erase && secured)); // R8
   AST_REJECT_ON_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (ext_wr && !ext_erase && secured) |=> ext_reject); // R8
   AST_SECURE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) secured |=> secured); // R9
   AST_FETCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !$past(fetch_en) |-> $stable(fetch_data)); // R10
endmodule

bind otp_secure_ctrl otp_secure_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_rd    (ext_rd),
   .ext_wr    (ext_wr),
   .ext_erase (ext_erase),
   .ext_sel   (ext_sel),
   .ext_rdata (ext_rdata),
   .ext_rvalid(ext_rvalid),
   .ext_reject(ext_reject),
   .fetch_en  (fetch_en),
   .fetch_data(fetch_data),
   .secured   (secured)
);

// File: tb/tb_otp_secure_ctrl.sv
module tb_otp_secure_ctrl;
   localparam int DEPTH = 256;
   localparam int DW    = 8;
   localparam int AW    = 8;
   localparam int USRN  = 8;
   localparam int SECB  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] ext_addr = '0;
   logic [DW-1:0] ext_wdata = '0;
   logic [1:0]    ext_sel = '0;
   logic          ext_rd = 1'b0, ext_wr = 1'b0, ext_erase = 1'b0;
   logic [DW-1:0] ext_rdata;
   logic          ext_rvalid, ext_reject;
   logic          fetch_en = 1'b0;
   logic [AW-1:0] fetch_addr = '0;
   logic [DW-1:0] fetch_data;

   always #2 clk = ~clk;

   otp_secure_ctrl #(.DEPTH(DEPTH), .DW(DW), .USR_N(USRN), .SEC_BIT(SECB)) dut (
      .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_sel(ext_sel), .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_erase(ext_erase),
      .ext_rdata(ext_rdata), .ext_rvalid(ext_rvalid), .ext_reject(ext_reject),
      .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_data(fetch_data)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_mem [DEPTH];
   logic [7:0] m_cfg;
   logic [7:0] m_usr [USRN];
   logic [7:0] exp_q [$];
   string      tag_q [$];

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic m_sec();
      return ~m_cfg[SECB];
   endfunction

   function automatic logic [7:0] m_read(input logic [1:0] sel, input logic [AW-1:0] a);
      case (sel)
         2'd0:    return m_sec() ? 8'hFF : m_mem[a];
         2'd1:    return m_cfg;
         2'd2:    return m_sec() ? 8'hFF : m_usr[a[2:0]];
         default: return 8'hFF;
      endcase
   endfunction

   // One operation: strobes for one cycle, then checks reject and fetch.
   task automatic step(input string tag, input logic rd, input logic wr, input logic er,
                       input logic [1:0] sel, input logic [AW-1:0] a, input logic [7:0] wd,
                       input logic fe, input logic [AW-1:0] fa);
      logic [7:0] fexp;
      logic       rexp;
      logic       s;
      @(negedge clk);
      ext_rd = rd; ext_wr = wr; ext_erase = er; ext_sel = sel;
      ext_addr = a; ext_wdata = wd; fetch_en = fe; fetch_addr = fa;
      s = m_sec();
      if (rd) begin
         exp_q.push_back(m_read(sel, a));
         tag_q.push_back(tag);
      end
      fexp = m_mem[fa];
      rexp = wr && s && !er;
      if (er) begin
         for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
         for (int i = 0; i < USRN; i++) m_usr[i] = 8'hFF;
         m_cfg = s ? (8'hFF & ~(8'h01 << SECB)) : 8'hFF;
      end else if (wr && !s) begin
         case (sel)
            2'd0: m_mem[a] = m_mem[a] & wd;
            2'd1: m_cfg = m_cfg & wd;
            2'd2: m_usr[a[2:0]] = m_usr[a[2:0]] & wd;
            default: ;
         endcase
      end
      @(negedge clk);
      ext_rd = 1'b0; ext_wr = 1'b0; ext_erase = 1'b0; fetch_en = 1'b0;
      if (wr || er) chk({tag, " reject"}, {7'b0, ext_reject}, {7'b0, rexp});
      if (fe) chk({tag, " fetch"}, fetch_data, fexp);
   endtask

   task automatic rd_op(input string tag, input logic [1:0] sel, input logic [AW-1:0] a);
      step(tag, 1'b1, 1'b0, 1'b0, sel, a, 8'h00, 1'b0, '0);
   endtask

   task automatic wr_op(input string tag, input logic [1:0] sel, input logic [AW-1:0] a, input logic [7:0] wd);
      step(tag, 1'b0, 1'b1, 1'b0, sel, a, wd, 1'b0, '0);
   endtask

   task automatic fe_op(input string tag, input logic [AW-1:0] fa);
      step(tag, 1'b0, 1'b0, 1'b0, 2'd0, '0, 8'h00, 1'b1, fa);
   endtask

   // Monitor: pops the scoreboard whenever read data is presented.
   always @(negedge clk) begin
      if (rst_n && ext_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R2: actual rvalid with data %h expected no read data", ext_rdata);
         end else begin
            chk(tag_q.pop_front(), ext_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
      for (int i = 0; i < USRN; i++) m_usr[i] = 8'hFF;
      m_cfg = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs and blank contents
      chk("R1 rvalid", {7'b0, ext_rvalid}, 8'h00);
      chk("R1 reject", {7'b0, ext_reject}, 8'h00);
      rd_op("R1 array0", 2'd0, 8'd0);
      rd_op("R1 array255", 2'd0, 8'd255);
      rd_op("R1 cfg", 2'd1, 8'd0);
      rd_op("R1 user", 2'd2, 8'd4);
      fe_op("R1", 8'd17);
      // R3: AND programming, R2 readback
      wr_op("R3", 2'd0, 8'd5, 8'hA5);
      rd_op("R3 first", 2'd0, 8'd5);
      wr_op("R3", 2'd0, 8'd5, 8'h0F);
      rd_op("R3 and", 2'd0, 8'd5);
      wr_op("R3", 2'd0, 8'd255, 8'h3C);
      rd_op("R2 top", 2'd0, 8'd255);
      wr_op("R3 user", 2'd2, 8'd2, 8'h55);
      rd_op("R3 user", 2'd2, 8'd2);
      wr_op("R3 cfg", 2'd1, 8'd0, 8'hFE);
      rd_op("R3 cfg", 2'd1, 8'd0);
      wr_op("R2 none", 2'd3, 8'd9, 8'h00);
      rd_op("R2 none", 2'd3, 8'd9);
      fe_op("R10 unsecured", 8'd5);
      // R11: write with read and fetch of the same address in one cycle
      step("R11 same", 1'b1, 1'b1, 1'b0, 2'd0, 8'd7, 8'h00, 1'b1, 8'd7);
      rd_op("R11 after", 2'd0, 8'd7);
      // R11 and R4: erase beats write
      step("R11 erase", 1'b0, 1'b1, 1'b1, 2'd0, 8'd9, 8'h00, 1'b0, '0);
      rd_op("R4 array", 2'd0, 8'd5);
      rd_op("R4 array9", 2'd0, 8'd9);
      rd_op("R4 user", 2'd2, 8'd2);
      rd_op("R4 cfg", 2'd1, 8'd0);
      // R5: protect the part
      wr_op("R3 reprog", 2'd0, 8'd5, 8'h5A);
      wr_op("R3 reprog", 2'd2, 8'd1, 8'h12);
      wr_op("R5", 2'd1, 8'd0, 8'hF7);
      rd_op("R7 cfg", 2'd1, 8'd0);
      rd_op("R6 array", 2'd0, 8'd5);
      rd_op("R6 user", 2'd2, 8'd1);
      fe_op("R10 secured", 8'd5);
      // R8: every write refused
      wr_op("R8 array", 2'd0, 8'd5, 8'h00);
      fe_op("R8 unchanged", 8'd5);
      wr_op("R8 cfg", 2'd1, 8'd0, 8'h00);
      rd_op("R8 cfg", 2'd1, 8'd0);
      wr_op("R8 user", 2'd2, 8'd1, 8'h00);
      wr_op("R8 none", 2'd3, 8'd1, 8'h00);
      // R9: erase keeps protection
      step("R9 erase", 1'b0, 1'b0, 1'b1, 2'd0, '0, 8'h00, 1'b0, '0);
      fe_op("R4 erased", 8'd5);
      rd_op("R9 cfg", 2'd1, 8'd0);
      rd_op("R9 array", 2'd0, 8'd5);
      wr_op("R9 array", 2'd0, 8'd3, 8'h00);
      fe_op("R9 unchanged", 8'd3);
      wr_op("R9 cfg", 2'd1, 8'd0, 8'h00);
      rd_op("R9 cfg after", 2'd1, 8'd0);
      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule